// File: doc/BRIEF.md
# Nibble-Serial Request Packet Receiver

This block sits on the target side of a narrow point-to-point link. The request channel is a 4-bit data bus with a frame marker. The receiver watches that bus and pairs successive nibbles into bytes. It parses each read or write request packet into its fields. When the last byte of a packet arrives, it presents the whole decoded request for one cycle: opcode, size code, transaction tag, byte-enable mask, 64-bit address and write data.

A packet may begin only where the frame input is high. The receiver takes the packet length from the first byte. A read request carries eleven header bytes. A write request carries the same header plus 1, 2, 4 or 8 data bytes. Packets that break the format rules are still taken in to their computed end and delivered with an error flag. A new frame marker that arrives in the middle of a packet cuts that packet off. The receiver raises an abort pulse and starts again on the new packet.

Top module: `nib_req_rx`

## Requirements
- R1: Outside a packet, nibbles are ignored while the frame input is low. A packet starts only in a cycle where the frame input is high.
- R2: Each byte is formed from two consecutive nibbles. The first nibble is bits 3:0 and the second is bits 7:4. The nibble sampled with the frame input high is the low half of byte 0.
- R3: In byte 0, bits 5:4 are the size code and bits 2:0 the opcode. The legal opcodes are 0 (full write), 1 (partial write) and 4 (read). These fields appear on req_size_o and req_opcode_o.
- R4: Byte 1 is the transaction tag and byte 2 the mask. Bytes 3 through 10 are the address, least significant byte first.
- R5: A packet with opcode 0 or 1 is 11 + 2^size bytes long. Data bytes follow byte 10, least significant first. Any other opcode gives an 11-byte packet.
- R6: req_valid_o is high for exactly one cycle. That cycle directly follows the clock edge that samples the final nibble, and the outputs hold the decoded fields during it.
- R7: req_err_o is high with req_valid_o in three cases: byte 0 bits 7:6 or bit 3 are nonzero, the opcode is not legal, or address bits 2:0 are nonzero. Such a packet is still consumed to its computed end.
- R8: A frame high while a packet is in progress drops that packet. It raises abort_o for the one cycle after that edge and starts a new packet with that nibble. No req_valid_o is produced for the dropped packet.
- R9: Data bits above 8*2^size are zero on req_data_o. A packet whose opcode is not 0 or 1 delivers all-zero data.
- R10: After reset, req_valid_o and abort_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nib_i | input | 4 | Request nibble bus |
| frame_i | input | 1 | High on the first nibble of a packet |
| req_valid_o | output | 1 | One-cycle pulse for a decoded request |
| req_err_o | output | 1 | Delivered packet broke a format rule |
| req_opcode_o | output | 3 | Request opcode |
| req_size_o | output | 2 | Size code, payload is 2^size bytes |
| req_tid_o | output | 8 | Transaction tag |
| req_mask_o | output | 8 | Byte-enable mask |
| req_addr_o | output | 64 | Request address |
| req_data_o | output | 64 | Write data, zero above the payload size |
| abort_o | output | 1 | Packet cut off by an early frame |

## Verification
The assertions assume that every complete packet spans at least 22 nibbles, so two valid pulses can never sit next to each other. They also assume that a frame mark is a single cycle high and never lands on the cycle that finishes a packet. The stimulus drives the frame input high for only the first nibble of each packet and puts at least one idle nibble between packets. Aborts come only from frames that arrive inside a packet. The sweep covers every opcode and size code, and it sends malformed headers and misaligned addresses with correct lengths, so the length rule is always defined by the first byte.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int unsigned HDR_BYTES = 11;
  localparam int unsigned ADDR_LO   = 3;   // byte index of address LSB
  localparam logic [2:0]  OP_PUT_FULL = 3'd0;
  localparam logic [2:0]  OP_PUT_PART = 3'd1;
  localparam logic [2:0]  OP_GET      = 3'd4;

  function automatic logic op_is_put(input logic [2:0] op);
    return (op == OP_PUT_FULL) || (op == OP_PUT_PART);
  endfunction

  function automatic logic op_legal(input logic [2:0] op);
    return op_is_put(op) || (op == OP_GET);
  endfunction
endpackage

// File: rtl/rx_nib_asm.sv
module rx_nib_asm #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       nib_i,
  input  logic             frame_i,
  input  logic [IDX_W-1:0] len_i,
  output logic             start_o,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             abort_o
);
  logic             active_q, hi_q, abort_q;
  logic [3:0]       lo_q;
  logic [IDX_W-1:0] idx_q;

  assign start_o    = frame_i;
  assign byte_vld_o = active_q && hi_q && !frame_i;
  assign byte_o     = {nib_i, lo_q};
  assign idx_o      = idx_q;
  assign abort_o    = abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hi_q     <= 1'b0;
      lo_q     <= '0;
      idx_q    <= '0;
      abort_q  <= 1'b0;
    end else begin
      abort_q <= frame_i && active_q;
      if (frame_i) begin
        active_q <= 1'b1;
        hi_q     <= 1'b1;
        lo_q     <= nib_i;
        idx_q    <= '0;
      end else if (active_q) begin
        if (!hi_q) begin
          lo_q <= nib_i;
          hi_q <= 1'b1;
        end else begin
          hi_q  <= 1'b0;
          idx_q <= idx_q + IDX_W'(1);
          if (idx_q == len_i - IDX_W'(1)) active_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rx_check.sv
module rx_check #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bad_o
);
  import rx_pkg::*;
  logic hdr_bad, addr_bad;

  always_comb begin
    hdr_bad  = (idx_i == '0) &&
               ((byte_i[7:6] != 2'b00) || byte_i[3] || !op_legal(byte_i[2:0]));
    addr_bad = (idx_i == IDX_W'(ADDR_LO)) && (byte_i[2:0] != 3'b000);
    bad_o    = byte_vld_i && (hdr_bad || addr_bad);
  end
endmodule

// File: rtl/rx_fields.sv
module rx_fields #(
  parameter int unsigned ADDR_BYTES = 8,
  parameter int unsigned DATA_BYTES = 8,
  parameter int unsigned IDX_W      = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    byte_vld_i,
  input  logic [7:0]              byte_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic [IDX_W-1:0]        len_o,
  output logic                    last_o,
  output logic [7:0]              hdr_nxt_o,
  output logic [7:0]              tid_nxt_o,
  output logic [7:0]              mask_nxt_o,
  output logic [8*ADDR_BYTES-1:0] addr_nxt_o,
  output logic [8*DATA_BYTES-1:0] data_nxt_o,
  output logic                    err_nxt_o
);
  import rx_pkg::*;
  localparam int unsigned DATA_LO = ADDR_LO + ADDR_BYTES;

  logic [7:0]              hdr_q, tid_q, mask_q;
  logic [8*ADDR_BYTES-1:0] addr_q;
  logic [8*DATA_BYTES-1:0] data_q;
  logic                    err_q, bad;

  rx_check #(.IDX_W(IDX_W)) u_check (
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .idx_i(idx_i), .bad_o(bad)
  );

  always_comb begin
    hdr_nxt_o  = (byte_vld_i && idx_i == IDX_W'(0)) ? byte_i : hdr_q;
    tid_nxt_o  = (byte_vld_i && idx_i == IDX_W'(1)) ? byte_i : tid_q;
    mask_nxt_o = (byte_vld_i && idx_i == IDX_W'(2)) ? byte_i : mask_q;
    err_nxt_o  = err_q | bad;
    len_o      = IDX_W'(HDR_BYTES) +
                 (op_is_put(hdr_q[2:0]) ? (IDX_W'(1) << hdr_q[5:4]) : IDX_W'(0));
    last_o     = byte_vld_i && (idx_i == len_o - IDX_W'(1));
  end

  for (genvar a = 0; a < ADDR_BYTES; a++) begin : g_addr
    assign addr_nxt_o[8*a +: 8] =
      (byte_vld_i && idx_i == IDX_W'(ADDR_LO + a)) ? byte_i : addr_q[8*a +: 8];
  end

  for (genvar d = 0; d < DATA_BYTES; d++) begin : g_data
    assign data_nxt_o[8*d +: 8] =
      (byte_vld_i && idx_i == IDX_W'(DATA_LO + d)) ? byte_i : data_q[8*d +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q  <= '0;
      tid_q  <= '0;
      mask_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (start_i) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      hdr_q  <= hdr_nxt_o;
      tid_q  <= tid_nxt_o;
      mask_q <= mask_nxt_o;
      addr_q <= addr_nxt_o;
      data_q <= data_nxt_o;
      err_q  <= err_nxt_o;
    end
  end
endmodule

// File: rtl/nib_req_rx.sv
module nib_req_rx #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        nib_i,
  input  logic              frame_i,
  output logic              req_valid_o,
  output logic              req_err_o,
  output logic [2:0]        req_opcode_o,
  output logic [1:0]        req_size_o,
  output logic [7:0]        req_tid_o,
  output logic [7:0]        req_mask_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_data_o,
  output logic              abort_o
);
  import rx_pkg::*;
  localparam int unsigned ADDR_BYTES = ADDR_W / 8;
  localparam int unsigned DATA_BYTES = DATA_W / 8;
  localparam int unsigned MAX_BYTES  = HDR_BYTES + DATA_BYTES;
  localparam int unsigned IDX_W      = $clog2(MAX_BYTES + 1);

  logic             start, byte_vld, last, err_nxt;
  logic [7:0]       byte_val, hdr_nxt, tid_nxt, mask_nxt;
  logic [IDX_W-1:0] idx, len;
  logic [ADDR_W-1:0] addr_nxt;
  logic [DATA_W-1:0] data_nxt;

  rx_nib_asm #(.IDX_W(IDX_W)) u_asm (
    .clk_i(clk_i), .rst_ni(rst_ni), .nib_i(nib_i), .frame_i(frame_i),
    .len_i(len), .start_o(start), .byte_vld_o(byte_vld), .byte_o(byte_val),
    .idx_o(idx), .abort_o(abort_o)
  );

  rx_fields #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES), .IDX_W(IDX_W)) u_fields (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .byte_vld_i(byte_vld),
    .byte_i(byte_val), .idx_i(idx), .len_o(len), .last_o(last),
    .hdr_nxt_o(hdr_nxt), .tid_nxt_o(tid_nxt), .mask_nxt_o(mask_nxt),
    .addr_nxt_o(addr_nxt), .data_nxt_o(data_nxt), .err_nxt_o(err_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_o  <= 1'b0;
      req_err_o    <= 1'b0;
      req_opcode_o <= '0;
      req_size_o   <= '0;
      req_tid_o    <= '0;
      req_mask_o   <= '0;
      req_addr_o   <= '0;
      req_data_o   <= '0;
    end else begin
      req_valid_o <= last;
      if (last) begin
        req_err_o    <= err_nxt;
        req_opcode_o <= hdr_nxt[2:0];
        req_size_o   <= hdr_nxt[5:4];
        req_tid_o    <= tid_nxt;
        req_mask_o   <= mask_nxt;
        req_addr_o   <= addr_nxt;
        req_data_o   <= data_nxt;
      end
    end
  end
endmodule

// File: rtl/rx_req_chk.sv
module rx_req_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_i,
  input logic              req_valid_o,
  input logic              req_err_o,
  input logic [2:0]        req_opcode_o,
  input logic [1:0]        req_size_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [DATA_W-1:0] req_data_o,
  input logic              abort_o
);
  assert_single_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);

  assert_valid_not_after_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !$past(frame_i));

  assert_abort_after_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(frame_i));

  assert_abort_valid_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(abort_o && req_valid_o));

  assert_clean_is_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_err_o) |->
      ((req_opcode_o == 3'd0 || req_opcode_o == 3'd1 || req_opcode_o == 3'd4) &&
       req_addr_o[2:0] == 3'b000));

  assert_data_above_size_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_size_o != 2'd3) |-> ((req_data_o >> (8 << req_size_o)) == '0));

  assert_read_data_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_opcode_o == 3'd4) |-> (req_data_o == '0));
endmodule

bind nib_req_rx rx_req_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .req_valid_o(req_valid_o),
  .req_err_o(req_err_o), .req_opcode_o(req_opcode_o), .req_size_o(req_size_o),
  .req_addr_o(req_addr_o), .req_data_o(req_data_o), .abort_o(abort_o)
);

// File: tb/sim_nib_req_rx.sv
module sim_nib_req_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  nib = 4'h0;
  logic        frame = 1'b0;
  logic        valid, err, abort;
  logic [2:0]  opcode;
  logic [1:0]  size;
  logic [7:0]  tid, mask;
  logic [63:0] addr, data;

  int checks = 0, errors = 0;
  int vcnt = 0, acnt = 0;
  logic [7:0] pkt [0:18];

  always #5 clk = ~clk;

  nib_req_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .nib_i(nib), .frame_i(frame),
    .req_valid_o(valid), .req_err_o(err), .req_opcode_o(opcode), .req_size_o(size),
    .req_tid_o(tid), .req_mask_o(mask), .req_addr_o(addr), .req_data_o(data),
    .abort_o(abort)
  );

  always @(posedge clk) begin
    if (valid) vcnt <= vcnt + 1;
    if (abort) acnt <= acnt + 1;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] got,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic build(input logic [2:0] op, input logic [1:0] sz, input logic [7:0] t,
                       input logic [7:0] m, input logic [63:0] a, input logic [63:0] d,
                       input logic [7:0] b0x);
    pkt[0] = {2'b00, sz, 1'b0, op} | b0x;
    pkt[1] = t;
    pkt[2] = m;
    for (int i = 0; i < 8; i++) pkt[3+i] = a[8*i +: 8];
    for (int i = 0; i < 8; i++) pkt[11+i] = d[8*i +: 8];
  endtask

  task automatic send(input int n_nib);
    for (int i = 0; i < n_nib; i++) begin
      @(negedge clk);
      frame = (i == 0);
      nib   = i[0] ? pkt[i/2][7:4] : pkt[i/2][3:0];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame = 1'b0;
      nib   = 4'(i + 7);
    end
  endtask

  task automatic run_pkt(input logic [2:0] op, input logic [1:0] sz, input logic [7:0] t,
                         input logic [7:0] m, input logic [63:0] a, input logic [63:0] d,
                         input logic [7:0] b0x, input logic exp_err);
    int          len, v0;
    logic        is_put;
    logic [63:0] dmask, exp_d;
    is_put = (op == 3'd0) || (op == 3'd1);
    len    = is_put ? 11 + (1 << sz) : 11;
    dmask  = (sz == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << sz)) - 64'd1);
    exp_d  = is_put ? (d & dmask) : 64'd0;
    v0     = vcnt;
    build(op, sz, t, m, a, d, b0x);
    send(2 * len);
    @(negedge clk);
    frame = 1'b0;
    nib   = 4'hA;
    chk(valid === 1'b1, "R6 valid after last nibble", 64'(valid), 64'd1);
    chk(opcode === op && size === sz, "R3 opcode/size", {59'd0, size, opcode}, {59'd0, sz, op});
    chk(tid === t && mask === m, "R4 tag/mask", {48'd0, tid, mask}, {48'd0, t, m});
    chk(addr === a, "R4 address", addr, a);
    chk(data === exp_d, "R9 data", data, exp_d);
    chk(err === exp_err, "R7 error flag", 64'(err), 64'(exp_err));
    @(negedge clk);
    nib = 4'h3;
    chk(valid === 1'b0, "R6 single-cycle valid", 64'(valid), 64'd0);
    chk(vcnt == v0 + 1, "R5 one delivery per packet", 64'(vcnt - v0), 64'd1);
  endtask

  initial begin
    int a0;
    #1;
    chk(valid === 1'b0 && abort === 1'b0, "R10 reset outputs", {62'd0, valid, abort}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(5);
    chk(vcnt == 0 && acnt == 0, "R1 idle nibbles ignored", 64'(vcnt + acnt), 64'd0);

    // R2 R3 R4 R5 R9: every opcode and size code
    a0 = acnt;
    for (int op = 0; op < 8; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        logic [7:0] t;
        t = 8'(op * 4 + sz + 'h30);
        idle(3);
        run_pkt(3'(op), 2'(sz), t, ~t,
                64'h0123_4567_89AB_CD00 ^ {48'd0, t, 8'd0},
                64'hF1E2_D3C4_B5A6_9788 + 64'(op * 17 + sz),
                8'h00, !(op == 0 || op == 1 || op == 4));
      end
    end
    chk(acnt == a0, "R8 no abort on clean packets", 64'(acnt - a0), 64'd0);

    // R7: malformed headers and misaligned address, still consumed to the end
    idle(2); run_pkt(3'd0, 2'd2, 8'h11, 8'h0F, 64'h1000, 64'h1122_3344_5566_7788, 8'h80, 1'b1);
    idle(2); run_pkt(3'd1, 2'd1, 8'h12, 8'h03, 64'h2000, 64'hAABB, 8'h40, 1'b1);
    idle(2); run_pkt(3'd4, 2'd3, 8'h13, 8'hFF, 64'h3000, 64'h0, 8'h08, 1'b1);
    idle(2); run_pkt(3'd4, 2'd0, 8'h14, 8'h01, 64'h4005, 64'h0, 8'h00, 1'b1);
    idle(2); run_pkt(3'd1, 2'd3, 8'h15, 8'hF0, 64'h5003, 64'hDEAD_BEEF_0BAD_F00D, 8'h00, 1'b1);
    idle(2); run_pkt(3'd0, 2'd0, 8'h16, 8'h01, 64'h6008, 64'h5A, 8'h00, 1'b0);

    // R8: frame inside a packet
    for (int k = 1; k < 30; k += 6) begin
      a0 = acnt;
      idle(2);
      build(3'd0, 2'd3, 8'hEE, 8'hEE, 64'hFFFF_0000_FFFF_0000, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
      send(k);
      run_pkt(3'd4, 2'd1, 8'h7C, 8'h42, 64'h0000_00AB_CDEF_0010, 64'h0, 8'h00, 1'b0);
      chk(acnt == a0 + 1, "R8 abort pulse on early frame", 64'(acnt - a0), 64'd1);
    end

    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule